// File: doc/BRIEF.md
# Two-Way Set-Associative Cache with LRU Replacement

This block is a small blocking cache placed between a processor's load/store path and a word-wide memory. It keeps `SETS` sets of two ways each; one block holds one data word. A request's word address picks a set by its low bits. The remaining upper bits form the tag, and the tag is compared against both ways of that set in the same cycle.

A read that hits returns the cached word without touching memory. A read that misses fetches the word over the memory port and installs it. The new block goes into an invalid way if the set has one; otherwise it replaces the way that one LRU bit per set marks as least recently used.

Writes always go to memory. A write that hits also refreshes the cached copy. A write that misses leaves the cache contents untouched.

The processor holds a request until the block answers with a one-cycle completion pulse. Only one request is serviced at a time.

Top module: `assoc2_cache`

## Requirements
- R1: After reset every way is invalid, `cpu_done` and `mem_valid` are low, and the first access to any address reports a miss.
- R2: The set is `req_addr mod SETS` (the low log2(SETS) address bits). The tag is the remaining upper bits. Filling one set never evicts blocks of another set.
- R3: Both ways of the selected set are compared at once. A read hit in either way completes with `cpu_hit`=1 and the cached word on `cpu_rdata`, and it starts no memory transaction.
- R4: A read miss issues exactly one memory read (`mem_we`=0, `mem_addr`=request address). On `mem_ready` it installs `mem_rdata` and returns it on `cpu_rdata` with `cpu_hit`=0.
- R5: On a read miss, an invalid way of the set is filled before any valid way is evicted. Way 0 is taken first when both ways are invalid.
- R6: With both ways valid, a read miss replaces the least recently used way. Every read hit, write hit and refill marks the other way of that set as least recently used.
- R7: A write hit updates the cached word and issues exactly one memory write (`mem_we`=1, `mem_addr`, `mem_wdata` equal to the request). `cpu_hit` is 1.
- R8: A write miss issues one memory write with `cpu_hit`=0 and does not allocate. A later read of that address misses and returns the written value.
- R9: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` hold steady.
- R10: With SETS=2, reading word addresses 0, 8, 0, 6, 8 after reset yields miss, miss, hit, miss, miss.
- R11: `cpu_done` is a single-cycle pulse per request. A refill completion (`mem_ready` on a read) is followed one cycle later by `cpu_done` with `cpu_hit`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; held until `cpu_done` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Write data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Access found its block in the cache (valid with `cpu_done`) |
| cpu_rdata | output | DATA_W | Read data (valid with `cpu_done` on reads) |
| mem_valid | output | 1 | Memory transaction pending |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ready | input | 1 | Memory completes the transaction this cycle |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ready` |

## Verification
A corrupted tag, valid bit or stored word makes the next read of that address disagree with the reference memory or the expected hit flag. That shows up on the very next access to the address. A wrong LRU bit or victim choice stays hidden until a third distinct block enters the set, and then appears as a hit where a miss was due, or the reverse. The directed eviction chains bring such errors out within two or three accesses. Random traffic over a small address window keeps sets full, so replacement errors surface within a few dozen requests.

// File: rtl/assoc2_cache.sv
module assoc2_cache #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SETS   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              cpu_done,
  output logic              cpu_hit,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int WAYS  = 2;

  typedef enum logic [1:0] {S_IDLE, S_CMP, S_MEM, S_DONE} st_t;
  st_t st;

  logic [ADDR_W-1:0] a_q;
  logic [DATA_W-1:0] wd_q;
  logic              w_q;
  logic              fill_q;
  logic              hit_q;
  logic [DATA_W-1:0] rd_q;

  logic [WAYS-1:0]   vld [SETS];
  logic [TAG_W-1:0]  tag_m [SETS][WAYS];
  logic [DATA_W-1:0] dat_m [SETS][WAYS];
  logic [SETS-1:0]   lru;

  logic [IDX_W-1:0] set_i;
  logic [TAG_W-1:0] tag_i;
  logic [WAYS-1:0]  hit_w;
  logic             hit, hit_way, victim;

  assign set_i = a_q[IDX_W-1:0];
  assign tag_i = a_q[ADDR_W-1:IDX_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_w[w] = vld[set_i][w] && (tag_m[set_i][w] == tag_i);
  end

  assign hit     = |hit_w;
  assign hit_way = hit_w[1];
  assign victim  = !vld[set_i][0] ? 1'b0 :
                   !vld[set_i][1] ? 1'b1 : lru[set_i];

  assign cpu_done  = (st == S_DONE);
  assign cpu_hit   = hit_q;
  assign cpu_rdata = rd_q;
  assign mem_valid = (st == S_MEM);
  assign mem_we    = w_q;
  assign mem_addr  = a_q;
  assign mem_wdata = wd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      a_q    <= '0;
      wd_q   <= '0;
      w_q    <= 1'b0;
      fill_q <= 1'b0;
      hit_q  <= 1'b0;
      rd_q   <= '0;
      lru    <= '0;
      for (int s = 0; s < SETS; s++) vld[s] <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          a_q  <= req_addr;
          wd_q <= req_wdata;
          w_q  <= req_write;
          st   <= S_CMP;
        end
        S_CMP: begin
          hit_q  <= hit;
          fill_q <= victim;
          if (hit) lru[set_i] <= ~hit_way;
          if (hit && !w_q) rd_q <= dat_m[set_i][hit_way];
          st <= (w_q || !hit) ? S_MEM : S_DONE;
        end
        S_MEM: if (mem_ready) begin
          if (!w_q) begin
            vld[set_i][fill_q] <= 1'b1;
            lru[set_i]         <= ~fill_q;
            rd_q               <= mem_rdata;
          end
          st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_CMP && hit && w_q)
      dat_m[set_i][hit_way] <= wd_q;
    else if (st == S_MEM && mem_ready && !w_q) begin
      dat_m[set_i][fill_q] <= mem_rdata;
      tag_m[set_i][fill_q] <= tag_i;
    end
  end
endmodule

// File: rtl/assoc2_cache_chk.sv
module assoc2_cache_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_done,
  input logic              cpu_hit,
  input logic              mem_valid,
  input logic              mem_we,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata
);
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);

  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_we) &&
                                   $stable(mem_addr) && $stable(mem_wdata)));

  assert_hit_no_mem_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_done && cpu_hit && !$past(mem_we)) |-> !$past(mem_valid));

  assert_miss_refill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_done && !cpu_hit) |-> ($past(mem_valid) && $past(mem_ready)));

  assert_refill_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !mem_we) |=> (cpu_done && !cpu_hit));

  assert_write_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && mem_we) |=> cpu_done);
endmodule

bind assoc2_cache assoc2_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_done(cpu_done), .cpu_hit(cpu_hit),
  .mem_valid(mem_valid), .mem_we(mem_we), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata));

// File: tb/assoc2_cache_tb_top.sv
module assoc2_cache_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NS = 2;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic cpu_done, cpu_hit, mem_valid, mem_we;
  logic [DW-1:0] cpu_rdata, mem_wdata;
  logic [AW-1:0] mem_addr;
  logic mem_ready = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assoc2_cache #(.ADDR_W(AW), .DATA_W(DW), .SETS(NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .cpu_done(cpu_done),
    .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata), .mem_valid(mem_valid),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata));

  int checks = 0, fails = 0;
  logic [DW-1:0] mem_arr [NW];
  int txn = 0;
  logic [AW-1:0] last_addr;
  logic last_we;
  logic [DW-1:0] last_wdata;

  // reference model
  logic [DW-1:0] ref_mem [NW];
  logic          rv [NS][2];
  logic [AW-1:0] rb [NS][2];
  logic          rl [NS];

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int set_of(input logic [AW-1:0] a);
    return int'(a) % NS;
  endfunction

  // memory model
  initial begin
    int dly = 0;
    for (int i = 0; i < NW; i++) begin
      mem_arr[i] = DW'(i * 37 + 11);
      ref_mem[i] = DW'(i * 37 + 11);
    end
    forever begin
      @(negedge clk);
      if (mem_ready) mem_ready = 1'b0;
      else if (mem_valid) begin
        if (dly == 0) begin
          txn++;
          last_addr = mem_addr; last_we = mem_we; last_wdata = mem_wdata;
          if (mem_we) mem_arr[mem_addr] = mem_wdata;
          else mem_rdata = mem_arr[mem_addr];
          mem_ready = 1'b1;
          dly = int'($urandom % 3);
        end else dly--;
      end
    end
  end

  // want: 0 expect miss, 1 expect hit, 2 no literal expectation
  task automatic acc(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input string req, input int want);
    int s = set_of(a);
    logic eh = 1'b0;
    logic ew = 1'b0;
    int t0 = txn;
    logic [DW-1:0] ed;
    for (int k = 0; k < 2; k++)
      if (rv[s][k] && rb[s][k] == a) begin eh = 1'b1; ew = k[0]; end
    ed = ref_mem[a];
    if (w) begin
      ref_mem[a] = d;
      if (eh) rl[s] = ~ew;
    end else if (eh) rl[s] = ~ew;
    else begin
      logic v = !rv[s][0] ? 1'b0 : !rv[s][1] ? 1'b1 : rl[s];
      rv[s][v] = 1'b1; rb[s][v] = a; rl[s] = ~v;
    end
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    do @(negedge clk); while (!cpu_done);
    req_valid = 1'b0;
    check(cpu_hit == eh, {req, " hit flag"}, cpu_hit, eh);
    if (want != 2) check(cpu_hit == want[0], {req, " expected pattern"}, cpu_hit, want);
    if (!w) check(cpu_rdata == ed, {req, " read data"}, cpu_rdata, ed);
    if (w || !eh) begin
      check(txn == t0 + 1, {req, " one memory transaction"}, txn - t0, 1);
      check(last_addr == a && last_we == w, {req, " memory addr/dir"}, {last_we, last_addr}, {w, a});
      if (w) check(last_wdata == d, {req, " memory write data"}, last_wdata, d);
    end else check(txn == t0, {req, " no memory transaction on read hit"}, txn - t0, 0);
    @(negedge clk);
    check(!cpu_done, "R11 done is one cycle", cpu_done, 0);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    for (int s = 0; s < NS; s++) begin rv[s][0] = 0; rv[s][1] = 0; rl[s] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!cpu_done && !mem_valid, "R1 idle after reset", {cpu_done, mem_valid}, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    acc(0, 8'd0, '0, "R10 R1 first read 0", 0);
    acc(0, 8'd8, '0, "R10 R5 read 8", 0);
    acc(0, 8'd0, '0, "R10 R3 read 0", 1);
    acc(0, 8'd6, '0, "R10 R6 read 6", 0);
    acc(0, 8'd8, '0, "R10 R6 read 8", 0);
    // other set does not disturb set 0 (R2)
    acc(0, 8'd1, '0, "R2 R5 read 1", 0);
    acc(0, 8'd3, '0, "R2 R5 read 3", 0);
    acc(0, 8'd8, '0, "R2 set0 kept 8", 1);
    acc(0, 8'd6, '0, "R2 set0 kept 6", 1);
    acc(0, 8'd1, '0, "R5 R3 read 1 both held", 1);
    acc(0, 8'd3, '0, "R5 R3 read 3 both held", 1);
    // LRU chain (R6)
    acc(0, 8'd1, '0, "R6 touch 1", 1);
    acc(0, 8'd5, '0, "R6 miss evicts 3", 0);
    acc(0, 8'd1, '0, "R6 1 retained", 1);
    acc(0, 8'd3, '0, "R6 3 evicted", 0);
    // write hit (R7)
    acc(1, 8'd3, 16'hBEEF, "R7 write hit", 1);
    acc(0, 8'd3, '0, "R7 read after write hit", 1);
    // write miss no allocate (R8)
    acc(1, 8'd9, 16'h1234, "R8 write miss", 0);
    acc(0, 8'd9, '0, "R8 read after write miss", 0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a = ($urandom % 4 == 0) ? AW'($urandom) : AW'($urandom % 12);
      acc(($urandom % 10) < 3, a, DW'($urandom), "R3 R4 R6 random", 2);
    end
    // reset clears contents (R1)
    do_reset();
    acc(0, 8'd0, '0, "R1 miss after reset", 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=complete");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule